// File: doc/BRIEF.md
# Prioritized Interrupt Collector

The collector gathers up to 128 level-sensitive interrupt lines into a single request for a processor. Software reaches it through a small 32-bit register bus with separate read and write strobes. Each source owns a three-bit control word, made of an enable and a two-bit priority level. Software changes the word through two write-only aliases: one sets bits and the other clears them, so software can update one source without a read-modify-write. A third alias in the same slot reads the word back.

An enabled source whose input is high is pending. Among the pending sources, the arbiter picks the one with the highest level, and the lower source number wins a tie. That choice is shown in a status register and drives the processor request. Servicing takes two steps. The handler reads the status, then writes the source number back to the vector register, which marks that source's level as in service. While any level is in service, only pending sources of a strictly higher level can raise the request. A later write of a one-hot level code to the level-acknowledge register ends service at the named levels. A self-clearing soft-reset bit returns all control words and all in-service state to zero.

Top module: `irq_collector`

## Requirements
- R1: After the reset input is released, every control word is zero, the request output is low, and the status register reads 0x0000007F.
- R2: Slot n occupies offsets 0x120+16n (plain read), 0x124+16n (set) and 0x128+16n (clear). A write to the set alias ORs wdata[2:0] into the word. A write to the clear alias clears the bits that are one in wdata[2:0]. Bits written as zero and wdata bits above 2 have no effect. A read of the plain alias returns the word in bits [2:0] and zeros elsewhere.
- R3: Bit 2 of a control word is the enable. A source whose enable is zero never raises the request and never appears in the status register, whatever its input does.
- R4: A read of offset 0x70 returns the winner's number in bits [6:0] and a one in bit 8. The winner is the eligible source with the highest level in word bits [1:0], and among equal levels the lowest source number.
- R5: When no source is eligible, the status reads 0x7F in bits [6:0] with bit 8 at zero, and the request is low.
- R6: A write of a source number to offset 0x0 marks that source's current level as in service. While any level is in service, only sources with a level strictly above the highest in-service level are eligible.
- R7: A write to offset 0x10 clears in service every level whose bit is one in wdata[3:0] (bit k is level k). Levels whose bit is zero stay in service.
- R8: Writing bit 31 at offset 0x20 starts a soft reset. That bit reads back as one for exactly one cycle. Afterwards every control word is zero and no level is in service.
- R9: Sources are level-sensitive. A source is pending only while its input is high, and it drops out of arbitration as soon as the input falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, taken at the clock edge |
| bus_rd | input | 1 | Read strobe, data returned in the same cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when no read is active |
| src_in | input | 128 | Level-sensitive interrupt inputs, bit n is source n |
| irq_out | output | 1 | Request to the processor |

## Verification
The hardest situation to reach from the ports is nested service. A low level is already in service when a higher-level source arrives and is allowed through. The request must then drop again once both sources are served, or come back when only the right level is acknowledged. The stimulus builds this up step by step. It enables sources at several levels and enters service for one of them through the vector register. It then raises a higher-level line and acknowledges a level that is not in service, followed by the level that is. The bench also runs the soft reset while a level is still in service. It then re-enables a source at that same level to show from the status register that the in-service state has gone.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NUM_LVL = 4;
  localparam int LVL_W   = 2;
  localparam int CW_W    = 3;
  localparam int EN_BIT  = 2;

  localparam logic [11:0] OFF_VEC   = 12'h000;
  localparam logic [11:0] OFF_LACK  = 12'h010;
  localparam logic [11:0] OFF_CTRL  = 12'h020;
  localparam logic [11:0] OFF_STAT  = 12'h070;
  localparam logic [11:0] SLOT_BASE = 12'h120;
  localparam logic [3:0]  SUB_RD    = 4'h0;
  localparam logic [3:0]  SUB_SET   = 4'h4;
  localparam logic [3:0]  SUB_CLR   = 4'h8;

  // Returns 1 when no in-service level is at or above lvl.
  function automatic logic above_service(input logic [LVL_W-1:0] lvl,
                                         input logic [NUM_LVL-1:0] insvc);
    logic ok;
    ok = 1'b1;
    for (int j = 0; j < NUM_LVL; j++)
      if (insvc[j] && (j >= int'(lvl))) ok = 1'b0;
    return ok;
  endfunction

  // Status word: id in [6:0], valid in bit 8; idle code all ones.
  function automatic logic [31:0] status_word(input logic valid,
                                              input logic [6:0] id);
    return {23'b0, valid, 1'b0, (valid ? id : 7'h7F)};
  endfunction
endpackage

// File: rtl/irqc_ctrl_bank.sv
module irqc_ctrl_bank
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 128,
  localparam int ID_W = $clog2(NUM_SRC)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr_all,
  input  logic                          set_we,
  input  logic                          clr_we,
  input  logic [ID_W-1:0]               sel_id,
  input  logic [CW_W-1:0]               wmask,
  output logic [NUM_SRC-1:0][CW_W-1:0]  ctrl
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_slot
    logic hit;
    assign hit = (sel_id == ID_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                ctrl[g] <= '0;
      else if (clr_all)          ctrl[g] <= '0;
      else if (set_we && hit)    ctrl[g] <= ctrl[g] | wmask;
      else if (clr_we && hit)    ctrl[g] <= ctrl[g] & ~wmask;
    end
  end
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 128,
  localparam int ID_W = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]            src_in,
  input  logic [NUM_SRC-1:0][CW_W-1:0]  ctrl,
  input  logic [NUM_LVL-1:0]            insvc,
  output logic                          win_valid,
  output logic [ID_W-1:0]               win_id,
  output logic [LVL_W-1:0]              win_lvl
);
  logic [NUM_SRC-1:0] elig;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_elig
    assign elig[g] = ctrl[g][EN_BIT] & src_in[g]
                   & above_service(ctrl[g][LVL_W-1:0], insvc);
  end

  // Scan downwards; ">=" lets the lower number take a tie.
  always_comb begin
    win_valid = 1'b0;
    win_id    = '1;
    win_lvl   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (elig[i] && (!win_valid || ctrl[i][LVL_W-1:0] >= win_lvl)) begin
        win_valid = 1'b1;
        win_id    = ID_W'(i);
        win_lvl   = ctrl[i][LVL_W-1:0];
      end
    end
  end
endmodule

// File: rtl/irqc_insvc.sv
module irqc_insvc
  import irqc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_all,
  input  logic               mark_we,
  input  logic [LVL_W-1:0]   mark_lvl,
  input  logic               ack_we,
  input  logic [NUM_LVL-1:0] ack_mask,
  output logic [NUM_LVL-1:0] insvc
);
  for (genvar k = 0; k < NUM_LVL; k++) begin : g_lvl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   insvc[k] <= 1'b0;
      else if (clr_all)                             insvc[k] <= 1'b0;
      else if (mark_we && mark_lvl == LVL_W'(k))    insvc[k] <= 1'b1;
      else if (ack_we && ack_mask[k])               insvc[k] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_collector.sv
module irq_collector
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 128,
  parameter int ADDR_W  = 12,
  localparam int ID_W = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_SRC-1:0] src_in,
  output logic               irq_out
);
  logic [NUM_SRC-1:0][CW_W-1:0] ctrl;
  logic [NUM_SRC-1:0]           en_vec;
  logic [NUM_LVL-1:0]           insvc;
  logic                         win_valid;
  logic [ID_W-1:0]              win_id;
  logic [LVL_W-1:0]             win_lvl;
  logic                         srst_q;

  // Address decode, brought out as named events.
  logic [ADDR_W-1:0] slot_off;
  logic [ID_W-1:0]   slot_id;
  logic              slot_hit;
  logic              set_we, clr_we, vec_we, ack_we, ctl_we;
  logic [ID_W-1:0]   vec_id;
  logic              vec_ok;
  logic [LVL_W-1:0]  vec_lvl;
  logic [NUM_LVL-1:0] ack_mask;

  assign slot_off = bus_addr - ADDR_W'(SLOT_BASE);
  assign slot_id  = slot_off[ID_W+3:4];
  assign slot_hit = (bus_addr >= ADDR_W'(SLOT_BASE))
                 && (int'(slot_off[ADDR_W-1:4]) < NUM_SRC);
  assign set_we   = bus_wr && slot_hit && slot_off[3:0] == SUB_SET;
  assign clr_we   = bus_wr && slot_hit && slot_off[3:0] == SUB_CLR;
  assign vec_id   = bus_wdata[ID_W-1:0];
  assign vec_ok   = int'(bus_wdata[30:0]) < NUM_SRC;
  assign vec_lvl  = ctrl[vec_id][LVL_W-1:0];
  assign vec_we   = bus_wr && bus_addr == ADDR_W'(OFF_VEC) && vec_ok;
  assign ack_we   = bus_wr && bus_addr == ADDR_W'(OFF_LACK);
  assign ack_mask = bus_wdata[NUM_LVL-1:0];
  assign ctl_we   = bus_wr && bus_addr == ADDR_W'(OFF_CTRL) && bus_wdata[31];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_en
    assign en_vec[g] = ctrl[g][EN_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      srst_q <= 1'b0;
    else if (srst_q) srst_q <= 1'b0;
    else             srst_q <= ctl_we;
  end

  irqc_ctrl_bank #(.NUM_SRC(NUM_SRC)) u_bank (
    .clk(clk), .rst_n(rst_n), .clr_all(srst_q),
    .set_we(set_we), .clr_we(clr_we), .sel_id(slot_id),
    .wmask(bus_wdata[CW_W-1:0]), .ctrl(ctrl)
  );

  irqc_insvc u_insvc (
    .clk(clk), .rst_n(rst_n), .clr_all(srst_q),
    .mark_we(vec_we), .mark_lvl(vec_lvl),
    .ack_we(ack_we), .ack_mask(ack_mask), .insvc(insvc)
  );

  irqc_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .src_in(src_in), .ctrl(ctrl), .insvc(insvc),
    .win_valid(win_valid), .win_id(win_id), .win_lvl(win_lvl)
  );

  assign irq_out = win_valid;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (bus_addr == ADDR_W'(OFF_STAT))
        bus_rdata = status_word(win_valid, 7'(win_id));
      else if (bus_addr == ADDR_W'(OFF_CTRL))
        bus_rdata = {srst_q, 31'b0};
      else if (slot_hit && slot_off[3:0] == SUB_RD)
        bus_rdata = {29'b0, ctrl[slot_id]};
    end
  end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 128,
  localparam int ID_W = $clog2(NUM_SRC)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               irq_out,
  input logic [NUM_SRC-1:0] src_in,
  input logic [NUM_SRC-1:0] en_vec,
  input logic [NUM_LVL-1:0] insvc,
  input logic               win_valid,
  input logic [ID_W-1:0]    win_id,
  input logic [LVL_W-1:0]   win_lvl,
  input logic               srst_q,
  input logic               vec_we,
  input logic [LVL_W-1:0]   vec_lvl,
  input logic               ack_we,
  input logic [NUM_LVL-1:0] ack_mask
);
  assert_irq_has_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> |(src_in & en_vec));

  assert_winner_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (src_in[win_id] && en_vec[win_id]));

  assert_idle_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_out |-> win_id == '1);

  assert_above_service_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (insvc >> win_lvl) == '0);

  assert_mark_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_we && !srst_q) |=> insvc[$past(vec_lvl)]);

  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_we && !vec_we && !srst_q) |=> (insvc & $past(ack_mask)) == '0);

  assert_soft_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> (en_vec == '0 && insvc == '0 && !srst_q));
endmodule

bind irq_collector irqc_checker #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_out(irq_out), .src_in(src_in),
  .en_vec(en_vec), .insvc(insvc), .win_valid(win_valid), .win_id(win_id),
  .win_lvl(win_lvl), .srst_q(srst_q), .vec_we(vec_we), .vec_lvl(vec_lvl),
  .ack_we(ack_we), .ack_mask(ack_mask)
);

// File: tb/irq_collector_bench.sv
module irq_collector_bench;
  localparam int N = 128;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  src_in = '0;
  logic          irq_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  irq_collector u_irq_collector (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_in(src_in), .irq_out(irq_out)
  );

  always #10 clk = ~clk;

  function automatic logic [11:0] slot(input int n, input int sub);
    return 12'(12'h120 + n * 16 + sub);
  endfunction

  function automatic logic [31:0] stat(input bit v, input int id);
    return v ? (32'h100 | 32'(id)) : 32'h7F;
  endfunction

  // Monitor: reads are sampled mid-cycle and compared with the queue.
  always @(negedge clk) begin
    if (bus_rd && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (bus_rdata !== e) begin
        bad++;
        $display("FAIL %s: rdata=%h expected=%h", t, bus_rdata, e);
      end
    end
  end

  // Driver tasks: called at posedge+2, each takes one cycle.
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #2;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); #2;
    bus_rd = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    total++;
    if (irq_out !== e) begin
      bad++;
      $display("FAIL %s: irq=%b expected=%b", t, irq_out, e);
    end
  endtask

  task automatic step_src(input int n, input logic v);
    src_in[n] = v;
    @(posedge clk); #2;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(posedge clk); #2;

    // R1 / R5: reset state
    rd(12'h070, stat(0, 0), "R1 status after reset");
    rd(slot(5, 0), 32'h0, "R1 slot word after reset");
    chk_irq(1'b0, "R5 idle request");

    // R2: set/clear aliases
    wr(slot(5, 4), 32'hFFFF_FFFF);
    rd(slot(5, 0), 32'h7, "R2 set alias, upper bits ignored");
    wr(slot(5, 8), 32'h1);
    rd(slot(5, 0), 32'h6, "R2 clear alias");
    wr(slot(5, 4), 32'h0);
    rd(slot(5, 0), 32'h6, "R2 zero bits unchanged");
    wr(slot(5, 8), 32'h2);
    rd(slot(5, 0), 32'h4, "R2 level cleared, enable kept");

    // R3: disabled source ignored
    step_src(9, 1'b1);
    chk_irq(1'b0, "R3 disabled source no request");
    rd(12'h070, stat(0, 0), "R3 disabled source not in status");

    // R9 / R4: level-sensitive pending
    step_src(5, 1'b1);
    chk_irq(1'b1, "R9 request while input high");
    rd(12'h070, stat(1, 5), "R4 single source status");
    step_src(5, 1'b0);
    chk_irq(1'b0, "R9 request drops with input");
    rd(12'h070, stat(0, 0), "R5 idle code after drop");

    // R4: priority and tie-break
    wr(slot(10, 4), 32'h5);
    wr(slot(20, 4), 32'h7);
    wr(slot(30, 4), 32'h7);
    wr(slot(40, 4), 32'h7);
    src_in[10] = 1'b1; src_in[20] = 1'b1; src_in[30] = 1'b1;
    @(posedge clk); #2;
    rd(12'h070, stat(1, 20), "R4 highest level, lowest number");
    step_src(20, 1'b0);
    rd(12'h070, stat(1, 30), "R4 next at top level");
    step_src(40, 1'b1);
    rd(12'h070, stat(1, 30), "R4 tie goes to lower number");
    step_src(40, 1'b0);

    // R6 / R7: nested service
    wr(12'h000, 32'd30);
    chk_irq(1'b0, "R6 level 3 in service blocks equal and lower");
    rd(12'h070, stat(0, 0), "R6 status idle under service");
    wr(12'h010, 32'h8);
    rd(12'h070, stat(1, 30), "R7 ack level 3 restores");
    step_src(30, 1'b0);
    rd(12'h070, stat(1, 10), "R4 lower level after top drops");
    wr(12'h000, 32'd10);
    rd(12'h070, stat(0, 0), "R6 level 1 in service");
    step_src(30, 1'b1);
    rd(12'h070, stat(1, 30), "R6 strictly higher level passes");
    chk_irq(1'b1, "R6 request for higher level");
    step_src(30, 1'b0);
    wr(12'h010, 32'h1);
    rd(12'h070, stat(0, 0), "R7 ack of other level leaves service");
    wr(12'h010, 32'h2);
    rd(12'h070, stat(1, 10), "R7 ack level 1 restores");

    // R8: soft reset with a level still in service
    wr(12'h000, 32'd10);
    wr(12'h020, 32'h8000_0000);
    rd(12'h020, 32'h8000_0000, "R8 reset bit visible one cycle");
    rd(12'h020, 32'h0, "R8 reset bit self-clears");
    rd(slot(10, 0), 32'h0, "R8 control word cleared");
    rd(slot(5, 0), 32'h0, "R8 enable cleared");
    chk_irq(1'b0, "R8 no request after soft reset");
    wr(slot(10, 4), 32'h5);
    rd(12'h070, stat(1, 10), "R8 in-service state cleared");

    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule